// File: doc/BRIEF.md
# IDE Interrupt Status and Gating Unit

This block sits in the local address space of an expansion card that carries up to three IDE ports. It gives software a byte-wide status register for each port. Bit 7 of that register shows the current level of the port's interrupt line, so a single handler can find out which port needs service. The block merges the port interrupt lines into one host interrupt. That host interrupt stays blocked after reset until software writes to a dedicated arm region. Some drives hold their interrupt line active while they power up, and the block must not pass those pulses on before the system has started.

The block also decodes the card's local offset into per-port, per-register-set selects for the IDE port logic, and passes offset bits 4..2 through as the IDE register index. A parameter chooses between a three-port build and a two-port build. In the two-port build the third port is treated as absent: its status always reads as idle, its interrupt is ignored, and its selects never fire.

Top module: `ide_irq_gate`

## Requirements
- R1: While `bus_rd` is high and `bus_ofs` is 0xF00, 0xF40 or 0xF80, `bus_rdata` bit 7 equals the current level of `ide_irq` bit 0, 1 or 2 respectively, and bits 6..0 are zero, in the same cycle.
- R2: Every offset inside the 64-byte block starting at a status offset reads the same as that status offset.
- R3: From reset until the cycle after the first arm write, `host_irq` is low whatever the levels on `ide_irq`.
- R4: A write cycle (`bus_wr` high) at any offset from 0xFC0 to 0xFFF arms forwarding. From the next cycle on, `host_irq` is the OR of the interrupt lines of the ports that are present.
- R5: Once armed, forwarding stays armed through any later read or write. Only `rst` disarms it.
- R6: Reads at the arm region, at any offset outside the status blocks, or with `bus_rd` low return 0x00. The arm state cannot be read back.
- R7: During a read or write at offsets 0x800..0xDFF, exactly one bit of `ide_sel` is high: bit n for the window that starts at 0x800+0x100*n. Bit 2p+s is port p, register set s. At all other times `ide_sel` is zero.
- R8: `ide_reg` always equals `bus_ofs` bits 4..2.
- R9: With `THREE_PORT` = 0, the port-2 status reads 0x00, `ide_irq` bit 2 never reaches `host_irq`, and `ide_sel` bits 5:4 stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ofs | input | 12 | Byte offset inside the card's local window |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_wr | input | 1 | Write strobe for the current cycle |
| ide_irq | input | 3 | Raw interrupt level of IDE ports 0..2 |
| bus_rdata | output | 8 | Read data for status offsets |
| host_irq | output | 1 | Gated, combined interrupt to the host bus |
| ide_sel | output | 6 | One-hot port/register-set select |
| ide_reg | output | 3 | IDE register index taken from offset bits 4..2 |

## Verification
The only state in the block is the arm flag. If it were wrong, `host_irq` would show it in the same cycle an enabled port raises its line. A flag that is stuck clear hides every interrupt after the arm write. A flag that is set too early, or that is cleared by a later access, shows up either as an interrupt during the pre-arm phase or as a lost interrupt after arming. Decode faults have no delay at all: a wrong window, a bad mirror mask or a leak from the two-port build shows on `bus_rdata` or `ide_sel` during the access cycle itself.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    localparam int OFS_W   = 12;
    localparam int NPORT   = 3;
    localparam int NSEL    = 2 * NPORT;
    localparam int WIN_W   = 3;
    localparam int PORT_W  = 2;
    localparam int REG_W   = 3;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_WIN  = 2'd1,
        RG_STAT = 2'd2,
        RG_ARM  = 2'd3
    } region_e;

    typedef struct packed {
        region_e              region;
        logic [WIN_W-1:0]     win_idx;
        logic [PORT_W-1:0]    stat_port;
        logic [REG_W-1:0]     reg_idx;
    } dec_t;

    // Classify a local offset into window, status block or arm block.
    function automatic dec_t decode_ofs(input logic [OFS_W-1:0] ofs);
        dec_t d;
        d.region    = RG_NONE;
        d.win_idx   = ofs[10:8];
        d.stat_port = ofs[7:6];
        d.reg_idx   = ofs[4:2];
        if (ofs[11] && (ofs[10:8] < WIN_W'(NSEL))) begin
            d.region = RG_WIN;
        end else if (ofs[11:8] == 4'hF) begin
            d.region = (ofs[7:6] == 2'b11) ? RG_ARM : RG_STAT;
        end
        return d;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import ide_irq_pkg::*;
#(
    parameter bit THREE_PORT = 1'b1
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic              rd,
    input  logic              wr,
    output logic [NSEL-1:0]   sel,
    output logic [REG_W-1:0]  reg_idx,
    output logic              stat_hit,
    output logic [PORT_W-1:0] stat_port,
    output logic              arm_hit
);
    localparam int NSEL_ACT = THREE_PORT ? NSEL : NSEL - 2;

    dec_t dec;
    logic access;

    always_comb begin
        dec = decode_ofs(ofs);
        access = rd | wr;
    end

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        if (i < NSEL_ACT) begin : g_live
            assign sel[i] = access && (dec.region == RG_WIN)
                            && (dec.win_idx == WIN_W'(i));
        end else begin : g_absent
            assign sel[i] = 1'b0;
        end
    end

    assign reg_idx   = dec.reg_idx;
    assign stat_hit  = rd && (dec.region == RG_STAT);
    assign stat_port = dec.stat_port;
    assign arm_hit   = wr && (dec.region == RG_ARM);
endmodule

// File: rtl/irq_arm_latch.sv
module irq_arm_latch (
    input  logic clk,
    input  logic rst,
    input  logic arm_hit,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (arm_hit) begin
            armed <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_status_mux.sv
module irq_status_mux
    import ide_irq_pkg::*;
#(
    parameter bit THREE_PORT = 1'b1
) (
    input  logic [NPORT-1:0]  irq_raw,
    input  logic              stat_hit,
    input  logic [PORT_W-1:0] stat_port,
    output logic [NPORT-1:0]  irq_live,
    output logic [7:0]        rdata
);
    localparam int NPORT_ACT = THREE_PORT ? NPORT : NPORT - 1;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        if (p < NPORT_ACT) begin : g_live
            assign irq_live[p] = irq_raw[p];
        end else begin : g_absent
            assign irq_live[p] = 1'b0;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int p = 0; p < NPORT; p++) begin
            if (stat_hit && (stat_port == PORT_W'(p))) begin
                rdata[7] = irq_live[p];
            end
        end
    end
endmodule

// File: rtl/ide_irq_gate.sv
module ide_irq_gate
    import ide_irq_pkg::*;
#(
    parameter bit THREE_PORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [NPORT-1:0]  ide_irq,
    output logic [7:0]        bus_rdata,
    output logic              host_irq,
    output logic [NSEL-1:0]   ide_sel,
    output logic [REG_W-1:0]  ide_reg
);
    logic              stat_hit;
    logic [PORT_W-1:0] stat_port;
    logic              arm_hit;
    logic              armed_q;
    logic [NPORT-1:0]  irq_live;

    irq_addr_decode #(.THREE_PORT(THREE_PORT)) u_dec (
        .ofs       (bus_ofs),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .sel       (ide_sel),
        .reg_idx   (ide_reg),
        .stat_hit  (stat_hit),
        .stat_port (stat_port),
        .arm_hit   (arm_hit)
    );

    irq_arm_latch u_arm (
        .clk     (clk),
        .rst     (rst),
        .arm_hit (arm_hit),
        .armed   (armed_q)
    );

    irq_status_mux #(.THREE_PORT(THREE_PORT)) u_stat (
        .irq_raw   (ide_irq),
        .stat_hit  (stat_hit),
        .stat_port (stat_port),
        .irq_live  (irq_live),
        .rdata     (bus_rdata)
    );

    assign host_irq = armed_q & (|irq_live);
endmodule

// File: rtl/ide_irq_gate_chk.sv
module ide_irq_gate_chk
    import ide_irq_pkg::*;
#(
    parameter bit THREE_PORT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [OFS_W-1:0] bus_ofs,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       bus_rdata,
    input logic             host_irq,
    input logic [NSEL-1:0]  ide_sel,
    input logic             armed
);
    logic seen_arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_arm <= 1'b0;
        end else if (bus_wr && (bus_ofs[11:6] == 6'h3F)) begin
            seen_arm <= 1'b1;
        end
    end

    // R3
    no_early_irq_chk: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> seen_arm);

    // R4
    arm_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_ofs[11:6] == 6'h3F)) |=> armed);

    // R5
    arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    // R1
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[6:0] == 7'd0);

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ide_sel));

    // R7
    sel_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
        (ide_sel != '0) |-> (bus_rd || bus_wr));

    // R9
    absent_port_sel_chk: assert property (@(posedge clk) disable iff (rst)
        !THREE_PORT |-> (ide_sel[5:4] == 2'b00));
endmodule

bind ide_irq_gate ide_irq_gate_chk #(.THREE_PORT(THREE_PORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_ofs   (bus_ofs),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .host_irq  (host_irq),
    .ide_sel   (ide_sel),
    .armed     (armed_q)
);

// File: tb/sim_ide_irq_gate.sv
`timescale 1ns/1ps
module sim_ide_irq_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] ofs = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  irq = '0;

    logic [7:0] rdata0, rdata1;
    logic       host0, host1;
    logic [5:0] sel0, sel1;
    logic [2:0] reg0, reg1;

    always #2 clk = ~clk;

    ide_irq_gate #(.THREE_PORT(1'b1)) u0 (
        .clk(clk), .rst(rst), .bus_ofs(ofs), .bus_rd(rd), .bus_wr(wr),
        .ide_irq(irq), .bus_rdata(rdata0), .host_irq(host0),
        .ide_sel(sel0), .ide_reg(reg0)
    );

    ide_irq_gate #(.THREE_PORT(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_ofs(ofs), .bus_rd(rd), .bus_wr(wr),
        .ide_irq(irq), .bus_rdata(rdata1), .host_irq(host1),
        .ide_sel(sel1), .ide_reg(reg1)
    );

    typedef struct {
        int       stamp;
        int       kind;
        logic [7:0] exp;
        string    tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;
    bit m_armed = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] m_rdata(logic [11:0] a, bit r, logic [2:0] v, bit three);
        logic [2:0] live;
        live = three ? v : {1'b0, v[1:0]};
        if (r && a[11:8] == 4'hF && a[7:6] != 2'b11)
            return {live[a[7:6]], 7'd0};
        return 8'h00;
    endfunction

    function automatic logic [7:0] m_sel(logic [11:0] a, bit r, bit w, bit three);
        int lim;
        lim = three ? 6 : 4;
        if ((r || w) && a[11] && int'(a[10:8]) < lim)
            return 8'(1 << a[10:8]);
        return 8'h00;
    endfunction

    function automatic logic [7:0] m_host(logic [2:0] v, bit three);
        logic [2:0] live;
        live = three ? v : {1'b0, v[1:0]};
        return {7'd0, m_armed & (|live)};
    endfunction

    function automatic void push(int kind, logic [7:0] e, string tag);
        item_t it;
        it.stamp = cyc; it.kind = kind; it.exp = e; it.tag = tag;
        q.push_back(it);
    endfunction

    // driver: apply one bus cycle and queue what the outputs must show
    task automatic step(bit r, bit w, logic [11:0] a, logic [2:0] v, string tag);
        @(posedge clk);
        #1;
        rd = r; wr = w; ofs = a; irq = v;
        if (rst) m_armed = 1'b0;
        push(0, m_rdata(a, r, v, 1'b1), tag);
        push(1, rst ? 8'h00 : m_host(v, 1'b1), tag);
        push(2, m_sel(a, r, w, 1'b1), tag);
        push(3, {5'd0, a[4:2]}, "R8");
        push(4, m_rdata(a, r, v, 1'b0), tag);
        push(5, rst ? 8'h00 : m_host(v, 1'b0), tag);
        push(6, m_sel(a, r, w, 1'b0), tag);
        if (!rst && w && a[11:6] == 6'h3F) m_armed = 1'b1;
    endtask

    // monitor: compare queued expectations in their cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = rdata0;
                1: act = {7'd0, host0};
                2: act = {2'd0, sel0};
                3: act = {5'd0, reg0};
                4: act = rdata1;
                5: act = {7'd0, host1};
                default: act = {2'd0, sel1};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                         it.tag, it.kind, cyc, act, it.exp);
            end
        end
    end

    initial begin
        // reset with all lines active: nothing forwarded
        rst = 1'b1;
        step(0, 0, 12'hF00, 3'b111, "R3");
        step(1, 0, 12'hF00, 3'b111, "R3");
        @(posedge clk); #1; rst = 1'b0;
        // R1 / R9: live status per port
        step(1, 0, 12'hF00, 3'b111, "R1");
        step(1, 0, 12'hF40, 3'b111, "R1");
        step(1, 0, 12'hF80, 3'b111, "R9");
        step(1, 0, 12'hF00, 3'b000, "R1");
        step(1, 0, 12'hF40, 3'b010, "R1");
        step(1, 0, 12'hF80, 3'b100, "R9");
        // R2: mirrors
        step(1, 0, 12'hF3F, 3'b001, "R2");
        step(1, 0, 12'hF55, 3'b010, "R2");
        step(1, 0, 12'hF7E, 3'b101, "R2");
        step(1, 0, 12'hFBF, 3'b100, "R2");
        step(1, 0, 12'hF9A, 3'b011, "R2");
        // R6: no read back of arm, other offsets read zero
        step(1, 0, 12'hFC0, 3'b111, "R6");
        step(1, 0, 12'hFFF, 3'b111, "R6");
        step(1, 0, 12'hE00, 3'b111, "R6");
        step(1, 0, 12'h7FE, 3'b111, "R6");
        step(0, 0, 12'hF00, 3'b111, "R6");
        // R7 / R8: window selects and register index
        step(1, 0, 12'h800, 3'b111, "R7");
        step(0, 1, 12'h9FC, 3'b111, "R7");
        step(1, 0, 12'hA10, 3'b000, "R7");
        step(0, 1, 12'hB1C, 3'b000, "R7");
        step(1, 0, 12'hC04, 3'b000, "R9");
        step(0, 1, 12'hDFF, 3'b000, "R9");
        step(0, 0, 12'hA08, 3'b000, "R7");
        step(1, 0, 12'h7FF, 3'b000, "R7");
        step(1, 0, 12'h840, 3'b000, "R8");
        // still not armed despite other writes
        step(0, 1, 12'hF00, 3'b111, "R3");
        step(0, 1, 12'hE40, 3'b111, "R3");
        step(0, 0, 12'h000, 3'b111, "R3");
        // arm
        step(0, 1, 12'hFC0, 3'b111, "R3");
        step(0, 0, 12'h000, 3'b001, "R4");
        step(0, 0, 12'h000, 3'b000, "R4");
        step(0, 0, 12'h000, 3'b010, "R4");
        step(0, 0, 12'h000, 3'b100, "R9");
        // R5: later accesses keep it armed
        step(0, 1, 12'hFFF, 3'b001, "R5");
        step(1, 0, 12'hFC0, 3'b001, "R5");
        step(0, 1, 12'h800, 3'b011, "R5");
        step(0, 1, 12'hF00, 3'b001, "R5");
        step(0, 0, 12'h000, 3'b110, "R5");
        // reset disarms
        rst = 1'b1;
        step(0, 0, 12'h000, 3'b111, "R5");
        @(posedge clk); #1; rst = 1'b0;
        step(0, 0, 12'h000, 3'b111, "R5");
        step(0, 1, 12'hFE3, 3'b111, "R4");
        step(0, 0, 12'h000, 3'b111, "R4");
        step(0, 0, 12'h000, 3'b100, "R9");
        @(posedge clk); @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 5000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule